// File: doc/BRIEF.md
# Quad I/O flash read sequencer

This block is the host side of a random-access read path to a serial NOR flash that talks over four data lines. A client gives it a 24-bit byte address, a byte count and a one-cycle start strobe. The block then runs one chip-select frame on the flash pins. Each byte it reads comes back to the client as a one-cycle valid pulse. A done pulse marks the end of the frame.

The frame has these phases in order: the quad read opcode, the address, a mode byte, a run of dummy clocks with the bus released, and the data nibbles. A configuration input sets the mode byte. When that byte has complementary nibbles, the flash stays in continuous-read mode. The block records this in an internal flag, and on the next frame it leaves out the opcode and starts with the address. A byte whose nibbles are not complementary clears the flag, and the opcode is sent again on the next frame. The flash's busy indication vetoes a start: the block stays deselected and raises an error pulse instead.

The serial clock comes from the system clock divided by an even ratio. It idles low. Outputs move on its falling edge and returned nibbles are sampled on its rising edge. Between frames, chip select is held high for a minimum number of system clocks.

Top module: `qrd_quad_reader`

## Requirements
- R1: After reset, flash_cs_n is 1, flash_sck is 0, io_oe is 0, ready is 1 and rd_valid, done and err are 0. The continuous flag is clear, so the first frame carries the opcode.
- R2: A frame with the flag clear first drives the opcode EBh over two beats, 4'hE then 4'hB. It then drives the address over six beats, nibble addr[23:20] first down to addr[3:0]. io_oe is 1 throughout and flash_cs_n is 0.
- R3: After the address, the mode byte goes out over two beats, upper nibble first, with io_oe set. It is A5h when cfg_cont was 1 at the accepted start and FFh when it was 0.
- R4: The mode byte is followed by DUMMY_CYC beats (default 4) with io_oe at 0. io_oe stays 0 through the data beats and whenever flash_cs_n is 1.
- R5: Data occupies 2*nbytes beats. io_in is sampled at each rising serial-clock edge. The even beat gives the upper nibble and the odd beat the lower nibble. One system clock after the odd beat's sample, rd_valid pulses for one cycle with rd_data = {upper, lower}.
- R6: After a frame whose mode byte had complementary nibbles (A5h), the next accepted frame starts directly with the address nibbles and sends no opcode.
- R7: After a frame whose mode byte had non-complementary nibbles (FFh), the next accepted frame sends the opcode again.
- R8: A start in the idle state while flash_busy is 1 begins no frame. flash_cs_n stays 1, err is 1 for exactly the next cycle, and the continuous flag is unchanged.
- R9: A start in the idle state with nbytes = 0 is refused in the same way as in R8: err pulses and no frame begins.
- R10: While selected, each beat lasts CLK_DIV system clocks. flash_sck is low for the first CLK_DIV/2 of them and high for the rest. flash_sck is 0 whenever flash_cs_n is 1.
- R11: done pulses for one cycle in the cycle in which flash_cs_n rises after the last data beat. flash_cs_n then stays 1 and ready stays 0 for CS_GAP cycles. A start while ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a read; taken only while ready |
| addr | input | ADDR_W | Start byte address |
| nbytes | input | CNT_W | Number of bytes to read (0 is refused) |
| cfg_cont | input | 1 | 1: request continuous mode (A5h), 0: normal (FFh) |
| ready | output | 1 | Idle, a start will be considered |
| rd_data | output | 8 | Byte read from flash |
| rd_valid | output | 1 | rd_data holds a new byte this cycle |
| done | output | 1 | Frame finished |
| err | output | 1 | Start refused (busy or zero count) |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock, idles low |
| io_out | output | 4 | Nibble driven to the flash data lines |
| io_oe | output | 1 | Drive enable for io_out |
| io_in | input | 4 | Nibble returned on the flash data lines |
| flash_busy | input | 1 | Flash has a program or erase cycle running |

## Verification
The frames alternate between cfg_cont values so that the opcode is shown to appear, vanish and return as the mode flag moves. The same flag value is also kept across a busy refusal, which shows that a refused start leaves the flag alone. Addresses with distinct nibbles, and one near the top of the space, separate a nibble-order or shift error from a phase-length error. Byte counts from one to five tell an off-by-one in the data phase apart from a packing error. A start raised in the middle of a frame, and a start with a zero count, check that only well-formed starts in the idle state reach the pins.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_ADDR  = 3'd2,
      ST_MODE  = 3'd3,
      ST_DUMMY = 3'd4,
      ST_DATA  = 3'd5,
      ST_GAP   = 3'd6
   } qrd_state_e;

   localparam logic [7:0] QREAD_OP = 8'hEB;

   // complementary nibbles keep the flash in continuous-read mode
   function automatic logic nib_compl(input logic [7:0] b);
      return b[7:4] == ~b[3:0];
   endfunction

endpackage

// File: rtl/qrd_sck_gen.sv
module qrd_sck_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic beat_end,
   output logic sample_pt
);

   generate
      if (CLK_DIV == 2) begin : g_div2
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= 1'b0;
            else        ph_q <= run ? ~ph_q : 1'b0;
         end
         assign sck       = run && ph_q;
         assign beat_end  = run && ph_q;
         assign sample_pt = run && ph_q;
      end else begin : g_divn
         localparam int HALF = CLK_DIV / 2;
         localparam int CW   = $clog2(CLK_DIV);
         logic [CW-1:0] cnt_q;
         logic          wrap;
         assign wrap = (cnt_q == CW'(CLK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!run || wrap)  cnt_q <= '0;
            else                    cnt_q <= cnt_q + CW'(1);
         end
         assign sck       = run && (cnt_q >= CW'(HALF));
         assign beat_end  = run && wrap;
         assign sample_pt = run && (cnt_q == CW'(HALF));
      end
   endgenerate

endmodule

// File: rtl/qrd_mode_track.sv
module qrd_mode_track
   import qrd_pkg::*;
#(
   parameter logic [7:0] KEEP_CODE = 8'hA5,
   parameter logic [7:0] EXIT_CODE = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       want_cont,
   input  logic       commit,
   output logic [7:0] mode_byte,
   output logic       cont_q
);

   assign mode_byte = want_cont ? KEEP_CODE : EXIT_CODE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cont_q <= 1'b0;
      else if (commit) cont_q <= nib_compl(mode_byte);
   end

endmodule

// File: rtl/qrd_rx_pack.sv
module qrd_rx_pack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       hi_half,
   input  logic [3:0] nib_in,
   output logic [7:0] byte_o,
   output logic       valid_o
);

   logic [3:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= take && !hi_half;
         if (take && hi_half)  hi_q   <= nib_in;
         if (take && !hi_half) byte_o <= {hi_q, nib_in};
      end
   end

endmodule

// File: rtl/qrd_quad_reader.sv
module qrd_quad_reader
   import qrd_pkg::*;
#(
   parameter int         ADDR_W    = 24,
   parameter int         CNT_W     = 16,
   parameter int         CLK_DIV   = 4,
   parameter int         DUMMY_CYC = 4,
   parameter int         CS_GAP    = 4,
   parameter logic [7:0] KEEP_CODE = 8'hA5,
   parameter logic [7:0] EXIT_CODE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  nbytes,
   input  logic              cfg_cont,
   output logic              ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              err,
   output logic              flash_cs_n,
   output logic              flash_sck,
   output logic [3:0]        io_out,
   output logic              io_oe,
   input  logic [3:0]        io_in,
   input  logic              flash_busy
);

   localparam int ADDR_NIB = ADDR_W / 4;
   localparam int BW_DATA  = CNT_W + 1;
   localparam int BW_DUM   = $clog2(DUMMY_CYC + 1);
   localparam int BW_ADR   = $clog2(ADDR_NIB + 1);
   localparam int BW_A     = (BW_DATA > BW_DUM) ? BW_DATA : BW_DUM;
   localparam int BW       = (BW_A > BW_ADR) ? BW_A : BW_ADR;
   localparam int GW       = $clog2(CS_GAP + 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (ADDR_W < 4 || (ADDR_W % 4) != 0) begin : g_bad_addr
         $error("ADDR_W must be a positive multiple of 4");
      end
      if (DUMMY_CYC < 1) begin : g_bad_dummy
         $error("DUMMY_CYC must be at least 1");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("CS_GAP must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (KEEP_CODE[7:4] != ~KEEP_CODE[3:0]) begin : g_bad_keep
         $error("KEEP_CODE needs complementary nibbles");
      end
      if (EXIT_CODE[7:4] == ~EXIT_CODE[3:0]) begin : g_bad_exit
         $error("EXIT_CODE must not have complementary nibbles");
      end
   endgenerate

   qrd_state_e        state_q, state_d;
   logic [BW-1:0]     beat_q;
   logic [BW-1:0]     len_m1;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_sh;
   logic              cfg_q;
   logic [GW-1:0]     gap_q;
   logic              done_q;
   logic              err_q;

   logic run, beat_end, sample_pt, last_beat, phase_done, reject;
   logic commit, take, cont_active;
   logic [7:0] mode_byte;

   assign run = (state_q == ST_CMD)  || (state_q == ST_ADDR) ||
                (state_q == ST_MODE) || (state_q == ST_DUMMY) ||
                (state_q == ST_DATA);

   qrd_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .sck       (flash_sck),
      .beat_end  (beat_end),
      .sample_pt (sample_pt)
   );

   assign commit = (state_q == ST_MODE) && phase_done;

   qrd_mode_track #(.KEEP_CODE(KEEP_CODE), .EXIT_CODE(EXIT_CODE)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_cont (cfg_q),
      .commit    (commit),
      .mode_byte (mode_byte),
      .cont_q    (cont_active)
   );

   assign take = (state_q == ST_DATA) && sample_pt;

   qrd_rx_pack u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .hi_half (!beat_q[0]),
      .nib_in  (io_in),
      .byte_o  (rd_data),
      .valid_o (rd_valid)
   );

   // last beat index of the current phase
   always_comb begin
      case (state_q)
         ST_CMD:   len_m1 = BW'(1);
         ST_ADDR:  len_m1 = BW'(ADDR_NIB - 1);
         ST_MODE:  len_m1 = BW'(1);
         ST_DUMMY: len_m1 = BW'(DUMMY_CYC - 1);
         ST_DATA:  len_m1 = (BW'(cnt_q) << 1) - BW'(1);
         default:  len_m1 = '0;
      endcase
   end

   assign last_beat  = (beat_q == len_m1);
   assign phase_done = beat_end && last_beat;
   assign reject     = flash_busy || (nbytes == '0);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start && !reject) state_d = cont_active ? ST_ADDR : ST_CMD;
         ST_CMD:   if (phase_done) state_d = ST_ADDR;
         ST_ADDR:  if (phase_done) state_d = ST_MODE;
         ST_MODE:  if (phase_done) state_d = ST_DUMMY;
         ST_DUMMY: if (phase_done) state_d = ST_DATA;
         ST_DATA:  if (phase_done) state_d = ST_GAP;
         ST_GAP:   if (gap_q == GW'(CS_GAP - 1)) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         cnt_q   <= '0;
         addr_sh <= '0;
         cfg_q   <= 1'b0;
         gap_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         if (state_q == ST_IDLE && start) begin
            err_q <= reject;
            if (!reject) begin
               addr_sh <= addr;
               cnt_q   <= nbytes;
               cfg_q   <= cfg_cont;
               beat_q  <= '0;
            end
         end
         if (beat_end) beat_q <= last_beat ? '0 : beat_q + BW'(1);
         if (state_q == ST_ADDR && beat_end) addr_sh <= addr_sh << 4;
         if (state_q == ST_DATA && phase_done) done_q <= 1'b1;
         gap_q <= (state_q == ST_GAP) ? gap_q + GW'(1) : '0;
      end
   end

   // nibble presented for the current beat
   always_comb begin
      case (state_q)
         ST_CMD:  io_out = beat_q[0] ? QREAD_OP[3:0] : QREAD_OP[7:4];
         ST_ADDR: io_out = addr_sh[ADDR_W-1 -: 4];
         ST_MODE: io_out = beat_q[0] ? mode_byte[3:0] : mode_byte[7:4];
         default: io_out = 4'h0;
      endcase
   end

   assign io_oe      = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_MODE);
   assign flash_cs_n = !run;
   assign ready      = (state_q == ST_IDLE);
   assign done       = done_q;
   assign err        = err_q;

endmodule

// File: rtl/qrd_quad_reader_chk.sv
module qrd_quad_reader_chk #(
   parameter int CNT_W   = 16,
   parameter int CLK_DIV = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] nbytes,
   input logic             ready,
   input logic             rd_valid,
   input logic             done,
   input logic             err,
   input logic             flash_cs_n,
   input logic             flash_sck,
   input logic             io_oe,
   input logic             flash_busy
);

   localparam int HALF = CLK_DIV / 2;

   int hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_run <= 0;
      else        hi_run <= flash_sck ? hi_run + 1 : 0;
   end

   // R10: high half of a serial clock never stretches
   always_ff @(posedge clk) begin
      if (rst_n) begin
         a_r10_high_half_len : assert (hi_run <= HALF)
            else $error("serial clock high for too long");
      end
   end

   a_r10_sck_low_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      flash_cs_n |-> !flash_sck);

   a_r4_bus_free_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      flash_cs_n |-> !io_oe);

   a_r11_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_at_cs_rise : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flash_cs_n && !$past(flash_cs_n)));

   a_r8_err_stays_idle : assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (flash_cs_n && ready));

   a_r8_busy_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && flash_busy) |=> (flash_cs_n && err));

   a_r9_zero_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && nbytes == '0) |=> (flash_cs_n && err));

   a_r11_good_start_selects : assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready && !flash_busy && nbytes != '0) |=> !flash_cs_n);

   a_r5_valid_single : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind qrd_quad_reader qrd_quad_reader_chk #(.CNT_W(CNT_W), .CLK_DIV(CLK_DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .nbytes     (nbytes),
   .ready      (ready),
   .rd_valid   (rd_valid),
   .done       (done),
   .err        (err),
   .flash_cs_n (flash_cs_n),
   .flash_sck  (flash_sck),
   .io_oe      (io_oe),
   .flash_busy (flash_busy)
);

// File: tb/tb_qrd_quad_reader.sv
module tb_qrd_quad_reader;

   localparam int DIV   = 4;
   localparam int HALF  = DIV / 2;
   localparam int DUM   = 4;
   localparam int GAP   = 4;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [23:0]      addr = '0;
   logic [CNT_W-1:0] nbytes = '0;
   logic             cfg_cont = 1'b0;
   logic             flash_busy = 1'b0;
   logic [3:0]       io_in = '0;
   logic             ready, rd_valid, done, err, flash_cs_n, flash_sck, io_oe;
   logic [7:0]       rd_data;
   logic [3:0]       io_out;

   always #4 clk = ~clk;

   qrd_quad_reader #(
      .ADDR_W(24), .CNT_W(CNT_W), .CLK_DIV(DIV), .DUMMY_CYC(DUM), .CS_GAP(GAP)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .nbytes(nbytes),
      .cfg_cont(cfg_cont), .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .done(done), .err(err), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
      .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .flash_busy(flash_busy)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] fbyte(input logic [23:0] a, input int i);
      return a[7:0] ^ 8'h6B ^ 8'(i * 29);
   endfunction

   // input snapshot taken at each rising edge
   logic             s_start, s_busy, s_cfg;
   logic [CNT_W-1:0] s_n;
   logic [23:0]      s_addr;
   always @(posedge clk) begin
      s_start <= start;
      s_busy  <= flash_busy;
      s_cfg   <= cfg_cont;
      s_n     <= nbytes;
      s_addr  <= addr;
   end

   // behavioural reference: list of beats per frame, time index since start
   bit         m_run = 0, m_cont = 0, e_err = 0, ev;
   int         j = 0, nb = 0, d0 = 0, ncmd = 0, bt, ph, t;
   int         nib_q[$];
   logic [7:0] byte_q[$];
   logic [7:0] eb, mb;
   string      tg;

   task automatic build();
      nib_q.delete();
      byte_q.delete();
      ncmd = m_cont ? 0 : 2;
      if (!m_cont) begin
         nib_q.push_back(14);
         nib_q.push_back(11);
      end
      for (int k = 5; k >= 0; k--) nib_q.push_back(int'(s_addr[4*k +: 4]));
      mb = s_cfg ? 8'hA5 : 8'hFF;
      nib_q.push_back(int'(mb[7:4]));
      nib_q.push_back(int'(mb[3:0]));
      for (int k = 0; k < DUM; k++) nib_q.push_back(-1);
      d0 = nib_q.size();
      for (int k = 0; k < int'(s_n); k++) begin
         byte_q.push_back(fbyte(s_addr, k));
         nib_q.push_back(-2);
         nib_q.push_back(-2);
      end
      nb = nib_q.size();
      m_cont = s_cfg;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_cont = 0; e_err = 0; j = 0;
         io_in = 4'h0;
      end else begin
         e_err = 0;
         if (!m_run) begin
            if (s_start) begin
               if (s_busy || s_n == '0) e_err = 1;
               else begin
                  build();
                  m_run = 1;
                  j = 0;
               end
            end
         end else begin
            j++;
            if (j == nb * DIV + GAP) m_run = 0;
         end

         if (m_run && j < nb * DIV) begin
            bt = j / DIV;
            ph = j % DIV;
            chk(flash_cs_n == 1'b0, "R2", "cs_n", flash_cs_n, 0);
            chk(flash_sck == (ph >= HALF), "R10", "sck", flash_sck, (ph >= HALF));
            tg = (bt >= d0) ? "R5" : (bt >= d0 - DUM) ? "R4" : "R2";
            chk(io_oe == (nib_q[bt] >= 0), tg, "io_oe", io_oe, (nib_q[bt] >= 0));
            if (nib_q[bt] >= 0) begin
               tg = (bt >= ncmd + 6) ? "R3" : (ncmd == 0) ? "R6" : "R2";
               chk(io_out == 4'(nib_q[bt]), tg, "io_out", io_out, nib_q[bt]);
            end
         end else begin
            chk(flash_cs_n == 1'b1, "R11", "cs_n high", flash_cs_n, 1);
            chk(flash_sck == 1'b0, "R10", "sck idle", flash_sck, 0);
            chk(io_oe == 1'b0, "R4", "io_oe idle", io_oe, 0);
         end
         chk(ready == !m_run, "R11", "ready", ready, !m_run);
         chk(done == (m_run && j == nb * DIV), "R11", "done", done, (m_run && j == nb * DIV));

         ev = 0;
         eb = 8'h00;
         if (m_run && j >= HALF + 1) begin
            t = j - 1 - HALF;
            if (t % DIV == 0) begin
               bt = t / DIV;
               if (bt >= d0 && bt < nb && ((bt - d0) % 2) == 1) begin
                  ev = 1;
                  eb = byte_q[(bt - d0) / 2];
               end
            end
         end
         chk(rd_valid == ev, "R5", "rd_valid", rd_valid, ev);
         if (ev) chk(rd_data == eb, "R5", "rd_data", rd_data, eb);
         chk(err == e_err, "R8", "err", err, e_err);

         // flash side: present data nibbles for the current beat
         io_in = 4'h0;
         if (m_run && j < nb * DIV) begin
            bt = j / DIV;
            if (bt >= d0) begin
               eb = byte_q[(bt - d0) / 2];
               io_in = (((bt - d0) % 2) == 0) ? eb[7:4] : eb[3:0];
            end
         end
      end
   end

   // nibbles the flash latches on rising serial-clock edges
   logic [3:0] rec_q[$];
   always @(posedge flash_sck) begin
      if (!flash_cs_n && io_oe) rec_q.push_back(io_out);
   end

   task automatic do_read(input logic [23:0] a, input int n, input bit c,
                          input bit want_cmd, input string req);
      @(negedge clk);
      rec_q.delete();
      addr = a; nbytes = CNT_W'(n); cfg_cont = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!ready) @(negedge clk);
      chk(rec_q.size() == (want_cmd ? 10 : 8), req, "driven nibble count",
          rec_q.size(), (want_cmd ? 10 : 8));
      if (rec_q.size() > 0)
         chk(rec_q[0] == (want_cmd ? 4'hE : a[23:20]), req, "first nibble",
             rec_q[0], (want_cmd ? 4'hE : a[23:20]));
   endtask

   task automatic do_refuse(input bit busy, input int n, input string req);
      @(negedge clk);
      rec_q.delete();
      addr = 24'h555555; nbytes = CNT_W'(n); cfg_cont = 1'b0;
      flash_busy = busy; start = 1'b1;
      @(negedge clk);
      start = 1'b0; flash_busy = 1'b0;
      chk(err == 1'b1, req, "err pulse", err, 1);
      chk(flash_cs_n == 1'b1, req, "stays deselected", flash_cs_n, 1);
      @(negedge clk);
      chk(err == 1'b0, req, "err one cycle", err, 0);
      chk(rec_q.size() == 0, req, "nothing driven", rec_q.size(), 0);
   endtask

   int cyc = 0;
   always @(negedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: state held during reset
      chk(flash_cs_n == 1'b1, "R1", "cs_n in reset", flash_cs_n, 1);
      chk(flash_sck == 1'b0, "R1", "sck in reset", flash_sck, 0);
      chk(io_oe == 1'b0, "R1", "io_oe in reset", io_oe, 0);
      chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
      chk((rd_valid | done | err) == 1'b0, "R1", "pulses in reset", {rd_valid, done, err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      do_read(24'h123456, 3, 1'b0, 1'b1, "R1");   // flag clear after reset
      do_read(24'hABCDEF, 2, 1'b1, 1'b1, "R7");   // previous byte FFh
      do_read(24'h000010, 1, 1'b1, 1'b0, "R6");   // previous byte A5h
      do_refuse(1'b1, 3, "R8");
      do_read(24'h345678, 2, 1'b0, 1'b0, "R8");   // flag survived refusal
      do_read(24'hFEDCBA, 5, 1'b0, 1'b1, "R7");
      do_refuse(1'b0, 0, "R9");

      // R11: a start in mid-frame is ignored
      @(negedge clk);
      rec_q.delete();
      addr = 24'h0F0F0F; nbytes = CNT_W'(4); cfg_cont = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(negedge clk);
      addr = 24'h777777; nbytes = CNT_W'(1); cfg_cont = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!ready) @(negedge clk);
      chk(rec_q.size() == 10, "R11", "one frame only", rec_q.size(), 10);
      if (rec_q.size() == 10)
         chk(rec_q[2] == 4'h0 && rec_q[3] == 4'hF, "R11", "first address kept",
             {rec_q[2], rec_q[3]}, 8'h0F);

      do_read(24'hFFFFFE, 1, 1'b0, 1'b0, "R6");
      do_read(24'h2468AC, 2, 1'b0, 1'b1, "R7");
      repeat (4) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule